// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block turns the address terms of one memory operand into an effective offset and a linear address. It also checks the access against the limit of the segment in use. The offset is built from an optional base register, an optional index register scaled by 1, 2, 4 or 8, and a displacement. Two relocation schemes are supported. In real mode a 16-bit segment value is multiplied by sixteen and added to the low 16 bits of the offset. In protected mode a cached descriptor base is added to the full offset.

Each request is a single-cycle strobe carrying all operand terms, the mode, the segment value and the cached descriptor fields. Exactly one clock later the block returns the linear address, the offset, a valid strobe and two fault flags: one for a limit violation and one for a descriptor that is not present. A new request may be issued every cycle. Fetching descriptors, loading selectors, comparing privilege and paging are left to neighbouring blocks.

Top module: `seg_ea_gen`

## Requirements
- R1: The offset equals (base if base_en, else 0) + (scaled index if index_en, else 0) + disp, taken modulo 2^32.
- R2: scale_code 0, 1, 2, 3 multiplies the index value by 1, 2, 4 and 8 respectively.
- R3: In real mode (prot_mode=0) the linear address is rseg*16 + offset[15:0]. The descriptor inputs have no effect on it.
- R4: In real mode the limit is 0xFFFF. rsp_gp_limit is set when offset + (acc_size+1) - 1 > 0xFFFF, where acc_size codes 0..3 mean 1..4 bytes. The sum is evaluated without wrap.
- R5: In protected mode (prot_mode=1) the linear address is dsc_base + offset modulo 2^32.
- R6: In protected mode the effective limit is dsc_limit when dsc_gran=0, and dsc_limit*4096 + 0xFFF when dsc_gran=1. rsp_gp_limit is set when offset + acc_size is greater than that limit, with the sum evaluated in 33 bits without wrap.
- R7: In protected mode, dsc_present=0 sets rsp_gp_absent. In real mode rsp_gp_absent is never set.
- R8: rsp_valid is high for a response only when neither fault flag is set. rsp_linear and rsp_offset are still driven for faulted responses.
- R9: The response appears on the clock edge after the one at which req_valid is sampled high, and back-to-back requests are answered on successive cycles. A cycle without a request gives rsp_valid=0 and both flags 0 in the next cycle, and rsp_linear and rsp_offset hold their values.
- R10: While reset is asserted, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, one operand per cycle |
| base_en | input | 1 | Base term present |
| base_val | input | 32 | Base register value |
| index_en | input | 1 | Index term present |
| index_val | input | 32 | Index register value |
| scale_code | input | 2 | Index scale: 0=x1, 1=x2, 2=x4, 3=x8 |
| disp | input | 32 | Displacement |
| acc_size | input | 2 | Access width minus one, in bytes |
| prot_mode | input | 1 | 0 = real mode, 1 = protected mode |
| rseg | input | 16 | Real-mode segment value |
| dsc_base | input | 32 | Cached descriptor base |
| dsc_limit | input | 20 | Cached descriptor limit |
| dsc_gran | input | 1 | Limit unit: 0 = byte, 1 = 4 KB |
| dsc_present | input | 1 | Descriptor present bit |
| rsp_linear | output | 32 | Linear address of the response |
| rsp_offset | output | 32 | Effective offset of the response |
| rsp_valid | output | 1 | Response usable, no fault |
| rsp_gp_limit | output | 1 | Limit fault on the response |
| rsp_gp_absent | output | 1 | Not-present fault on the response |

## Verification
The limit check and the presence check are independent and can both fire on the same response. The bench provokes this with a protected-mode request that has a clear present bit and an offset past a small byte-granular limit. It expects both flags high, the valid strobe low, and the linear address still equal to base plus offset. Byte-exact boundary vectors also place a limit fault next to offset wraparound. In these, an offset that wraps modulo 2^32 must relocate correctly, while an access end that runs past 2^32 must fault rather than wrap.

// File: rtl/seg_ea_pkg.sv
package seg_ea_pkg;
  parameter int AW      = 32;
  parameter int SEG_W   = 16;
  parameter int LIM_W   = 20;
  parameter int GRAN_SH = 12;
  parameter int SC_W    = 2;
  parameter int SZ_W    = 2;
  localparam int SEG_SH   = 4;
  localparam int REAL_OW  = SEG_W;
  localparam int NSCALE   = 1 << SC_W;
  localparam logic [AW:0] REAL_LIMIT = {{(AW+1-REAL_OW){1'b0}}, {REAL_OW{1'b1}}};

  function automatic logic [AW-1:0] seg_to_linear(input logic [SEG_W-1:0] seg,
                                                  input logic [AW-1:0] ofs);
    logic [AW-1:0] shifted;
    logic [AW-1:0] low;
    shifted = AW'({seg, {SEG_SH{1'b0}}});
    low     = AW'(ofs[REAL_OW-1:0]);
    return shifted + low;
  endfunction

  function automatic logic [AW:0] span_end(input logic [AW-1:0] ofs,
                                           input logic [SZ_W-1:0] sz);
    return {1'b0, ofs} + (AW+1)'(sz);
  endfunction

  function automatic logic [AW:0] gran_limit(input logic [LIM_W-1:0] lim,
                                             input logic gran);
    logic [AW-1:0] eff;
    if (gran) eff = AW'({lim, {GRAN_SH{1'b1}}});
    else      eff = AW'(lim);
    return {1'b0, eff};
  endfunction
endpackage

// File: rtl/ea_offset_unit.sv
module ea_offset_unit
  import seg_ea_pkg::*;
(
  input  logic            base_en,
  input  logic [AW-1:0]   base_val,
  input  logic            index_en,
  input  logic [AW-1:0]   index_val,
  input  logic [SC_W-1:0] scale_code,
  input  logic [AW-1:0]   disp,
  input  logic [SZ_W-1:0] acc_size,
  output logic [AW-1:0]   ofs,
  output logic [AW:0]     last_byte
);
  logic [AW-1:0] cand [NSCALE];
  logic [AW-1:0] idx_term;
  logic [AW-1:0] base_term;

  for (genvar k = 0; k < NSCALE; k++) begin : g_scale
    assign cand[k] = index_val << k;
  end

  always_comb begin
    idx_term  = index_en ? cand[scale_code] : '0;
    base_term = base_en ? base_val : '0;
    ofs       = base_term + idx_term + disp;
    last_byte = span_end(ofs, acc_size);
  end
endmodule

// File: rtl/ea_relocate.sv
module ea_relocate
  import seg_ea_pkg::*;
(
  input  logic             prot_mode,
  input  logic [SEG_W-1:0] rseg,
  input  logic [AW-1:0]    dsc_base,
  input  logic [AW-1:0]    ofs,
  output logic [AW-1:0]    linear
);
  logic [AW-1:0] real_lin;
  logic [AW-1:0] prot_lin;

  assign real_lin = seg_to_linear(rseg, ofs);
  assign prot_lin = dsc_base + ofs;
  assign linear   = prot_mode ? prot_lin : real_lin;
endmodule

// File: rtl/ea_limit_unit.sv
module ea_limit_unit
  import seg_ea_pkg::*;
(
  input  logic             prot_mode,
  input  logic [LIM_W-1:0] dsc_limit,
  input  logic             dsc_gran,
  input  logic             dsc_present,
  input  logic [AW:0]      last_byte,
  output logic [AW:0]      lim_eff,
  output logic             over_limit,
  output logic             not_present
);
  assign lim_eff     = prot_mode ? gran_limit(dsc_limit, dsc_gran) : REAL_LIMIT;
  assign over_limit  = last_byte > lim_eff;
  assign not_present = prot_mode & ~dsc_present;
endmodule

// File: rtl/seg_ea_gen.sv
module seg_ea_gen
  import seg_ea_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             base_en,
  input  logic [AW-1:0]    base_val,
  input  logic             index_en,
  input  logic [AW-1:0]    index_val,
  input  logic [SC_W-1:0]  scale_code,
  input  logic [AW-1:0]    disp,
  input  logic [SZ_W-1:0]  acc_size,
  input  logic             prot_mode,
  input  logic [SEG_W-1:0] rseg,
  input  logic [AW-1:0]    dsc_base,
  input  logic [LIM_W-1:0] dsc_limit,
  input  logic             dsc_gran,
  input  logic             dsc_present,
  output logic [AW-1:0]    rsp_linear,
  output logic [AW-1:0]    rsp_offset,
  output logic             rsp_valid,
  output logic             rsp_gp_limit,
  output logic             rsp_gp_absent
);
  logic [AW-1:0] ofs_w;
  logic [AW:0]   end_w;
  logic [AW:0]   lim_w;
  logic [AW-1:0] lin_w;
  logic          lim_fault_w;
  logic          abs_fault_w;

  ea_offset_unit u_ofs (
    .base_en(base_en), .base_val(base_val), .index_en(index_en),
    .index_val(index_val), .scale_code(scale_code), .disp(disp),
    .acc_size(acc_size), .ofs(ofs_w), .last_byte(end_w)
  );

  ea_relocate u_rel (
    .prot_mode(prot_mode), .rseg(rseg), .dsc_base(dsc_base),
    .ofs(ofs_w), .linear(lin_w)
  );

  ea_limit_unit u_lim (
    .prot_mode(prot_mode), .dsc_limit(dsc_limit), .dsc_gran(dsc_gran),
    .dsc_present(dsc_present), .last_byte(end_w), .lim_eff(lim_w),
    .over_limit(lim_fault_w), .not_present(abs_fault_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_linear    <= '0;
      rsp_offset    <= '0;
      rsp_valid     <= 1'b0;
      rsp_gp_limit  <= 1'b0;
      rsp_gp_absent <= 1'b0;
    end else begin
      rsp_valid     <= req_valid & ~lim_fault_w & ~abs_fault_w;
      rsp_gp_limit  <= req_valid & lim_fault_w;
      rsp_gp_absent <= req_valid & abs_fault_w;
      if (req_valid) begin
        rsp_linear <= lin_w;
        rsp_offset <= ofs_w;
      end
    end
  end
endmodule

// File: rtl/seg_ea_chk.sv
module seg_ea_chk
  import seg_ea_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          prot_mode,
  input logic          dsc_present,
  input logic [AW:0]   end_w,
  input logic [AW:0]   lim_w,
  input logic [AW-1:0] rsp_linear,
  input logic [AW-1:0] rsp_offset,
  input logic          rsp_valid,
  input logic          rsp_gp_limit,
  input logic          rsp_gp_absent
);
  p_valid_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!rsp_gp_limit && !rsp_gp_absent));

  p_answer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_valid || rsp_gp_limit || rsp_gp_absent));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_gp_limit && !rsp_gp_absent));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(rsp_linear) && $stable(rsp_offset)));

  p_absent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && prot_mode && !dsc_present) |=> rsp_gp_absent);

  p_real_present_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !prot_mode) |=> !rsp_gp_absent);

  p_real_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !prot_mode && end_w > REAL_LIMIT) |=> rsp_gp_limit);

  p_gran_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && prot_mode && end_w > lim_w) |=> rsp_gp_limit);
endmodule

bind seg_ea_gen seg_ea_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .prot_mode(prot_mode),
  .dsc_present(dsc_present), .end_w(end_w), .lim_w(lim_w),
  .rsp_linear(rsp_linear), .rsp_offset(rsp_offset), .rsp_valid(rsp_valid),
  .rsp_gp_limit(rsp_gp_limit), .rsp_gp_absent(rsp_gp_absent)
);

// File: tb/seg_ea_gen_bench.sv
module seg_ea_gen_bench;
  typedef struct packed {
    logic        be;
    logic [31:0] b;
    logic        ie;
    logic [31:0] idx;
    logic [1:0]  sc;
    logic [31:0] disp;
    logic [1:0]  sz;
    logic        prot;
    logic [15:0] seg;
    logic [31:0] dbase;
    logic [19:0] dlim;
    logic        gran;
    logic        pres;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 32'h1234, 1'b0, 32'h0, 2'd0, 32'h10, 2'd0, 1'b0, 16'h1000, 32'h0, 20'h0, 1'b0, 1'b1},
    '{1'b1, 32'h7000, 1'b1, 32'h100, 2'd3, 32'h0, 2'd0, 1'b0, 16'hFFFF, 32'h0, 20'h0, 1'b0, 1'b1},
    '{1'b0, 32'h0, 1'b0, 32'h0, 2'd0, 32'hFFFD, 2'd1, 1'b0, 16'h0200, 32'h0, 20'h0, 1'b0, 1'b1},
    '{1'b0, 32'h0, 1'b0, 32'h0, 2'd0, 32'hFFFE, 2'd3, 1'b0, 16'h0200, 32'h0, 20'h0, 1'b0, 1'b1},
    '{1'b0, 32'h0, 1'b0, 32'h0, 2'd0, 32'hFFC, 2'd3, 1'b1, 16'h0, 32'h00400000, 20'h00FFF, 1'b0, 1'b1},
    '{1'b0, 32'h0, 1'b0, 32'h0, 2'd0, 32'hFFD, 2'd3, 1'b1, 16'h0, 32'h00400000, 20'h00FFF, 1'b0, 1'b1},
    '{1'b1, 32'h1F00, 1'b1, 32'h40, 2'd2, 32'hFF, 2'd0, 1'b1, 16'h0, 32'h10000000, 20'h00001, 1'b1, 1'b1},
    '{1'b0, 32'h0, 1'b1, 32'h7FFFFFFF, 2'd1, 32'h0, 2'd3, 1'b1, 16'h0, 32'h0, 20'hFFFFF, 1'b1, 1'b1},
    '{1'b0, 32'h0, 1'b0, 32'h0, 2'd0, 32'h20, 2'd0, 1'b1, 16'h0, 32'h8000, 20'h000FF, 1'b0, 1'b0},
    '{1'b0, 32'h0, 1'b0, 32'h0, 2'd0, 32'h200, 2'd0, 1'b1, 16'h0, 32'h8000, 20'h000FF, 1'b0, 1'b0},
    '{1'b1, 32'hFFFFFFF0, 1'b0, 32'h0, 2'd0, 32'h20, 2'd1, 1'b1, 16'h0, 32'h100, 20'hFFFFF, 1'b1, 1'b1},
    '{1'b1, 32'h0ABC, 1'b1, 32'h3, 2'd1, 32'h1, 2'd2, 1'b0, 16'h0F00, 32'hDEADBEEF, 20'h0, 1'b1, 1'b0},
    '{1'b1, 32'h12345, 1'b1, 32'h2, 2'd0, 32'h0, 2'd0, 1'b0, 16'h0001, 32'h0, 20'h0, 1'b0, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        base_en = 1'b0, index_en = 1'b0, prot_mode = 1'b0;
  logic        dsc_gran = 1'b0, dsc_present = 1'b0;
  logic [31:0] base_val = '0, index_val = '0, disp = '0, dsc_base = '0;
  logic [1:0]  scale_code = '0, acc_size = '0;
  logic [15:0] rseg = '0;
  logic [19:0] dsc_limit = '0;
  logic [31:0] rsp_linear, rsp_offset;
  logic        rsp_valid, rsp_gp_limit, rsp_gp_absent;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  seg_ea_gen u_seg_ea_gen (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .base_en(base_en),
    .base_val(base_val), .index_en(index_en), .index_val(index_val),
    .scale_code(scale_code), .disp(disp), .acc_size(acc_size),
    .prot_mode(prot_mode), .rseg(rseg), .dsc_base(dsc_base),
    .dsc_limit(dsc_limit), .dsc_gran(dsc_gran), .dsc_present(dsc_present),
    .rsp_linear(rsp_linear), .rsp_offset(rsp_offset), .rsp_valid(rsp_valid),
    .rsp_gp_limit(rsp_gp_limit), .rsp_gp_absent(rsp_gp_absent)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      $display("FAIL R9 watchdog expired: actual %0d cycles, expected under 20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    req_valid = 1'b1;
    base_en = v.be; base_val = v.b; index_en = v.ie; index_val = v.idx;
    scale_code = v.sc; disp = v.disp; acc_size = v.sz; prot_mode = v.prot;
    rseg = v.seg; dsc_base = v.dbase; dsc_limit = v.dlim;
    dsc_gran = v.gran; dsc_present = v.pres;
  endtask

  task automatic check_vec(input vec_t v, input int n);
    logic [31:0] o, lin;
    logic [32:0] last, lim;
    logic lf, af;
    o = v.disp;
    if (v.be) o = o + v.b;
    if (v.ie) o = o + v.idx * (32'd1 << v.sc);
    last = {1'b0, o} + 33'(v.sz);
    if (v.prot) begin
      lin = v.dbase + o;
      lim = v.gran ? (33'(v.dlim) * 33'd4096 + 33'd4095) : 33'(v.dlim);
      af  = !v.pres;
    end else begin
      lin = 32'(v.seg) * 32'd16 + (o & 32'hFFFF);
      lim = 33'hFFFF;
      af  = 1'b0;
    end
    lf = last > lim;
    chk($sformatf("R1 offset vec %0d", n), rsp_offset, o);
    chk($sformatf("%s linear vec %0d", v.prot ? "R5" : "R3", n), rsp_linear, lin);
    chk($sformatf("%s limit fault vec %0d", v.prot ? "R6" : "R4", n), 32'(rsp_gp_limit), 32'(lf));
    chk($sformatf("R7 absent fault vec %0d", n), 32'(rsp_gp_absent), 32'(af));
    chk($sformatf("R8 valid vec %0d", n), 32'(rsp_valid), 32'(!lf && !af));
  endtask

  initial begin
    logic [31:0] last_lin;
    repeat (3) @(negedge clk);
    chk("R10 reset linear", rsp_linear, 32'h0);
    chk("R10 reset offset", rsp_offset, 32'h0);
    chk("R10 reset flags", {29'h0, rsp_valid, rsp_gp_limit, rsp_gp_absent}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 idle after reset", {29'h0, rsp_valid, rsp_gp_limit, rsp_gp_absent}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      @(negedge clk);
      check_vec(TBL[i], i);
    end
    req_valid = 1'b0;
    last_lin = rsp_linear;
    base_val = 32'h5555; disp = 32'h9999;
    @(negedge clk);
    chk("R9 idle quiet", {29'h0, rsp_valid, rsp_gp_limit, rsp_gp_absent}, 32'h0);
    chk("R9 idle hold linear", rsp_linear, last_lin);

    for (int s = 0; s < 4; s++) begin
      vec_t v;
      v = '{1'b0, 32'h0, 1'b1, 32'h11, 2'(s), 32'h0, 2'd0, 1'b1, 16'h0,
            32'h0, 20'hFFFFF, 1'b1, 1'b1};
      drive(v);
      @(negedge clk);
      chk($sformatf("R2 scale code %0d", s), rsp_offset, 32'h11 << s);
    end
    req_valid = 1'b0;
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule